// File: doc/BRIEF.md
# SPI Byte Exchange Engine

This block moves one byte in each direction over a four-wire synchronous serial link. A mode input makes it either the clock owner, which makes the serial clock and the select line, or the follower, which receives both. The serial clock idle level and the sampling edge can be set, which gives the four usual clock modes. Both ends of a link must use the same mode.

As clock owner, a 16-bit reload divisor of the system clock sets the toggle rate of the serial clock. One serial clock period is therefore two divisor periods. As follower, the incoming clock, select and data lines pass through two-flop synchronizers, and their edges are detected in the system clock domain. The incoming clock must run no faster than a quarter of the system clock.

Software-side access is a small register-style port. A write loads the byte to send, and when the block is clock owner the write also starts the transfer. The received byte can be read at any time. A completion flag and a write-collision flag report the state of the transfer.

Top module: `spi_byte_engine`

## Requirements
- R1: A transfer shifts exactly 8 bits each way, most significant bit first, over 8 serial clock cycles (16 clock edges when owner); after it the received byte appears on `rd_data`.
- R2: With `cfg_cpha`=0 data is sampled on the leading edge (idle-to-active) and changed on the trailing edge; with `cfg_cpha`=1 data changes on the leading edge and is sampled on the trailing edge; the serial clock idles at `cfg_cpol`.
- R3: As owner, each serial clock half period lasts max(`cfg_divisor`,2) system clocks, so a divisor of 0 or 1 behaves as 2.
- R4: As owner, `ss_n_o` is low exactly while `busy` is high and high otherwise; `sck_oe` equals `cfg_master`.
- R5: As follower with `cfg_cpha`=0, serial clock edges seen while select is high have no effect; the falling select drives the first bit on `miso_o` before any clock edge.
- R6: As follower with `cfg_cpha`=1, select may stay low across consecutive bytes, and each byte completes on its own.
- R7: `done` rises after the eighth sampling edge and is cleared by `rd_en` or by an accepted write; when a completion and `rd_en` fall in the same cycle, `done` ends up set.
- R8: A write while `busy` is high is ignored and sets `wcol`; `rd_en` clears `wcol`.
- R9: After reset `done`, `wcol` and `busy` are 0, `rd_data` is 0, `ss_n_o` is 1 and `sck_o` equals `cfg_cpol`.
- R10: As owner with `cfg_cpha`=0 the first bit is on `mosi_o` from the cycle after the starting write, before the first clock edge; with `cfg_cpha`=1 it appears with the first edge, and `mosi_o` changes only on the edge type that R2 assigns to driving.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_master | input | 1 | 1 = clock owner, 0 = follower |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | Sampling edge select |
| cfg_divisor | input | 16 | Half-period length in system clocks (owner) |
| wr_en | input | 1 | Write strobe for the transmit byte |
| wr_data | input | 8 | Transmit byte |
| rd_en | input | 1 | Read strobe; clears completion and collision flags |
| rd_data | output | 8 | Last received byte |
| done | output | 1 | Transfer complete flag |
| wcol | output | 1 | Write collision flag |
| busy | output | 1 | Transfer in progress |
| sck_o | output | 1 | Serial clock out (owner) |
| sck_oe | output | 1 | Serial clock output enable |
| ss_n_o | output | 1 | Select out, active low (owner) |
| mosi_o | output | 1 | Data out, owner side |
| miso_i | input | 1 | Data in, owner side |
| sck_i | input | 1 | Serial clock in (follower) |
| ss_n_i | input | 1 | Select in, active low (follower) |
| mosi_i | input | 1 | Data in, follower side |
| miso_o | output | 1 | Data out, follower side |

## Verification
Two events can fall in the same cycle: the completion that sets `done` and a read that clears it. The bench holds `rd_en` high through an owner transfer. Once `done` shows as 1, it drops `rd_en` and checks that the flag stays set and that the received byte is the one the peer sent. If the clear won, `done` would never be seen and the wait would time out as a failure. A second overlap is a write that arrives during a transfer. The bench checks that this write raises `wcol` and leaves the byte seen by the peer unchanged.

// File: rtl/spi_pkg.sv
// Shared types for the serial byte engine.
package spi_pkg;
    // Edge events seen on the serial clock: leading = idle-to-active.
    typedef struct packed {
        logic lead;
        logic trail;
    } spi_edge_t;
endpackage

// File: rtl/spi_sync.sv
// Two-flop synchronizer for a vector of asynchronous inputs.
// Assumes each bit is sampled independently; RST_VAL sets the reset state.
module spi_sync #(
    parameter int             W       = 3,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two register stages bring the inputs into the clk domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/spi_baud_gen.sv
// Reload down-counter that gives one tick every max(div,2) clocks while run is high.
// Assumes div is held stable during a run; the counter reloads while idle.
module spi_baud_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam logic [DIV_W-1:0] MIN_DIV = DIV_W'(2);

    logic [DIV_W-1:0] div_eff;
    logic [DIV_W-1:0] cnt;

    // Clamp the divisor so a half period is never shorter than two clocks.
    always_comb div_eff = (div < MIN_DIV) ? MIN_DIV : div;

    assign tick = run && (cnt == '0);

    // Count down while running, reload on expiry or when idle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || cnt == '0)
            cnt <= div_eff - 1'b1;
        else
            cnt <= cnt - 1'b1;
    end
endmodule

// File: rtl/spi_shift_core.sv
// Shared transmit/receive shifter with bit counter.
// Assumes at most one of ld, pre/shift_ev is meaningful per cycle; ld has priority.
module spi_shift_core #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld,
    input  logic              ld_pre,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              pre,
    input  logic              shift_ev,
    input  logic              sample_ev,
    input  logic              din,
    input  logic              abort,
    output logic              drv,
    output logic              mid_byte,
    output logic              byte_done,
    output logic [DATA_W-1:0] rx_byte
);
    localparam int               CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(DATA_W - 1);

    logic [DATA_W-1:0] tx_sh;
    logic [DATA_W-1:0] rx_sh;
    logic [CNT_W-1:0]  cnt;

    assign mid_byte  = (cnt != '0);
    assign byte_done = sample_ev && !abort && !ld && (cnt == LAST);

    // Transmit side: load, optional preload of the first bit, then MSB-first shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sh <= '0;
            drv   <= 1'b0;
        end else if (ld) begin
            if (ld_pre) begin
                drv   <= ld_data[DATA_W-1];
                tx_sh <= {ld_data[DATA_W-2:0], 1'b0};
            end else begin
                tx_sh <= ld_data;
            end
        end else if (pre || shift_ev) begin
            drv   <= tx_sh[DATA_W-1];
            tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
        end
    end

    // Receive side: collect bits, count them and latch the byte on the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_sh   <= '0;
            cnt     <= '0;
            rx_byte <= '0;
        end else if (abort || ld) begin
            cnt <= '0;
        end else if (sample_ev) begin
            rx_sh <= {rx_sh[DATA_W-2:0], din};
            cnt   <= (cnt == LAST) ? '0 : cnt + 1'b1;
            if (cnt == LAST)
                rx_byte <= {rx_sh[DATA_W-2:0], din};
        end
    end
endmodule

// File: rtl/spi_byte_engine.sv
// Serial byte engine, clock owner or follower, all four clock modes.
// Owner: clock from the baud divider, toggled per tick, select driven low for a transfer.
// Follower: synchronized clock/select/data, edges gated by select; clock <= clk/4 assumed.
// Configuration inputs are assumed static while busy.
module spi_byte_engine
    import spi_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_master,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic [DIV_W-1:0]  cfg_divisor,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              done,
    output logic              wcol,
    output logic              busy,
    output logic              sck_o,
    output logic              sck_oe,
    output logic              ss_n_o,
    output logic              mosi_o,
    input  logic              miso_i,
    input  logic              sck_i,
    input  logic              ss_n_i,
    input  logic              mosi_i,
    output logic              miso_o
);
    localparam int               EDGE_W    = $clog2(2 * DATA_W + 1);
    localparam logic [EDGE_W-1:0] EDGE_LAST = EDGE_W'(2 * DATA_W);

    // Owner-side state
    logic              tick;
    logic              m_act;
    logic              m_sck;
    logic              m_ss_n;
    logic [EDGE_W-1:0] m_edges;
    logic              m_step;

    // Follower-side state
    logic [2:0]        sync_q;
    logic              ss_s, sck_s, mosi_s;
    logic              ss_p, sck_p;
    logic              s_rise, s_fall, ss_fall, ss_rise;
    logic              s_busy;

    spi_edge_t         m_ev, s_ev, ev;
    logic              sample_ev, shift_ev, pre, abort;
    logic              wr_ok, wr_bad;
    logic              drv, mid_byte, byte_done;
    logic [DATA_W-1:0] rx_byte;

    spi_baud_gen #(.DIV_W(DIV_W)) u_baud (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (m_act),
        .div  (cfg_divisor),
        .tick (tick)
    );

    spi_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({ss_n_i, sck_i, mosi_i}),
        .q    (sync_q)
    );

    assign {ss_s, sck_s, mosi_s} = sync_q;

    // Previous synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ss_p  <= 1'b1;
            sck_p <= 1'b0;
        end else begin
            ss_p  <= ss_s;
            sck_p <= sck_s;
        end
    end

    assign s_rise  = sck_s & ~sck_p;
    assign s_fall  = ~sck_s & sck_p;
    assign ss_fall = ss_p & ~ss_s;
    assign ss_rise = ~ss_p & ss_s;

    // Follower edges count only while select is low.
    always_comb begin
        s_ev.lead  = !cfg_master && !ss_s && (cfg_cpol ? s_fall : s_rise);
        s_ev.trail = !cfg_master && !ss_s && (cfg_cpol ? s_rise : s_fall);
    end

    // Owner edges: one per baud tick until all 2*DATA_W edges are made.
    assign m_step = tick && m_act && (m_edges != EDGE_LAST);
    always_comb begin
        m_ev.lead  = m_step && (m_sck == cfg_cpol);
        m_ev.trail = m_step && (m_sck != cfg_cpol);
    end

    // Map edge types onto sample and drive events by clock phase.
    always_comb begin
        ev        = cfg_master ? m_ev : s_ev;
        sample_ev = cfg_cpha ? ev.trail : ev.lead;
        shift_ev  = cfg_cpha ? ev.lead  : ev.trail;
        pre       = !cfg_master && !cfg_cpha && ss_fall;
        abort     = !cfg_master && ss_rise;
    end

    assign s_busy = !ss_s && (!cfg_cpha || mid_byte);
    assign busy   = cfg_master ? m_act : s_busy;
    assign wr_ok  = wr_en && !busy;
    assign wr_bad = wr_en && busy;

    // Owner sequencer: start on write, toggle the clock per tick, release select one half period after the last edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_act   <= 1'b0;
            m_sck   <= 1'b0;
            m_ss_n  <= 1'b1;
            m_edges <= '0;
        end else if (!m_act) begin
            m_sck   <= cfg_cpol;
            m_edges <= '0;
            if (wr_ok && cfg_master) begin
                m_act  <= 1'b1;
                m_ss_n <= 1'b0;
            end
        end else if (tick) begin
            if (m_edges == EDGE_LAST) begin
                m_act  <= 1'b0;
                m_ss_n <= 1'b1;
            end else begin
                m_sck   <= ~m_sck;
                m_edges <= m_edges + 1'b1;
            end
        end
    end

    spi_shift_core #(.DATA_W(DATA_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld       (wr_ok),
        .ld_pre   (cfg_master && !cfg_cpha),
        .ld_data  (wr_data),
        .pre      (pre),
        .shift_ev (shift_ev),
        .sample_ev(sample_ev),
        .din      (cfg_master ? miso_i : mosi_s),
        .abort    (abort),
        .drv      (drv),
        .mid_byte (mid_byte),
        .byte_done(byte_done),
        .rx_byte  (rx_byte)
    );

    // Status flags: completion beats a same-cycle clear; collision held until read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
            wcol <= 1'b0;
        end else begin
            if (byte_done)
                done <= 1'b1;
            else if (rd_en || wr_ok)
                done <= 1'b0;
            if (wr_bad)
                wcol <= 1'b1;
            else if (rd_en)
                wcol <= 1'b0;
        end
    end

    assign rd_data = rx_byte;
    assign sck_o   = m_act ? m_sck : cfg_cpol;
    assign sck_oe  = cfg_master;
    assign ss_n_o  = m_ss_n;
    assign mosi_o  = drv;
    assign miso_o  = drv;
endmodule

// File: rtl/spi_byte_engine_chk.sv
// Property checker for the serial byte engine, attached by bind.
// Assumes configuration inputs stay static while busy.
module spi_byte_engine_chk #(
    parameter int DIV_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_master,
    input logic             cfg_cpol,
    input logic             cfg_cpha,
    input logic [DIV_W-1:0] cfg_divisor,
    input logic             wr_en,
    input logic             rd_en,
    input logic             done,
    input logic             wcol,
    input logic             busy,
    input logic             sck_o,
    input logic             ss_n_o,
    input logic             mosi_o
);
    logic [DIV_W:0] hp_cnt;
    logic           sck_q;
    logic           sck_chg;
    logic [DIV_W:0] hp_exp;

    assign sck_chg = (sck_o != sck_q);
    assign hp_exp  = (cfg_divisor < DIV_W'(2)) ? (DIV_W+1)'(2) : {1'b0, cfg_divisor};

    // Cycles since the last serial clock change of a running owner transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hp_cnt <= '0;
            sck_q  <= 1'b0;
        end else begin
            sck_q  <= sck_o;
            hp_cnt <= !busy ? '0 : (sck_chg ? (DIV_W+1)'(1) : hp_cnt + 1'b1);
        end
    end

    // R3: each half period of the owner clock lasts the clamped divisor.
    a_r3_half_period: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_master && busy && sck_chg) |-> (hp_cnt == hp_exp));

    // R4: owner select tracks the transfer.
    a_r4_select_tracks_busy: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_master |-> (ss_n_o == !busy));

    // R8: a write during a transfer raises the collision flag.
    a_r8_wcol_on_busy_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && busy) |=> wcol);

    // R7: a read in an idle owner clears completion.
    a_r7_read_clears_done: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_master && !busy && done && rd_en) |=> !done);

    // R10: during an owner transfer the data line moves only with a driving edge.
    a_r10_mosi_on_drive_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_master && busy && $past(busy) && (mosi_o != $past(mosi_o)))
            |-> ((sck_o != $past(sck_o)) && ((sck_o == cfg_cpol) == !cfg_cpha)));
endmodule

bind spi_byte_engine spi_byte_engine_chk #(.DIV_W(DIV_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_master (cfg_master),
    .cfg_cpol   (cfg_cpol),
    .cfg_cpha   (cfg_cpha),
    .cfg_divisor(cfg_divisor),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .done       (done),
    .wcol       (wcol),
    .busy       (busy),
    .sck_o      (sck_o),
    .ss_n_o     (ss_n_o),
    .mosi_o     (mosi_o)
);

// File: tb/tb_spi_byte_engine.sv
`timescale 1ns/1ps
// Bench: two engines in loopback (dut and peer) plus bit-banged follower tests.
module tb_spi_byte_engine;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic        cpol = 1'b0, cpha = 1'b0;
    logic [15:0] div = 16'd4;
    logic        d_master = 1'b1, p_master = 1'b0;
    logic        d_wr = 1'b0, p_wr = 1'b0, d_rd = 1'b0, p_rd = 1'b0;
    logic [7:0]  d_wdata = '0, p_wdata = '0;
    logic        bb_en = 1'b0, bb_sck = 1'b0, bb_ss = 1'b1, bb_mosi = 1'b0;

    logic [7:0]  d_rdata, p_rdata;
    logic        d_done, d_wcol, d_busy, d_sck_o, d_sck_oe, d_ss_o, d_mosi_o, d_miso_o;
    logic        p_done, p_wcol, p_busy, p_sck_o, p_sck_oe, p_ss_o, p_mosi_o, p_miso_o;

    int checks = 0;
    int errors = 0;
    bit ended = 0;

    spi_byte_engine dut (
        .clk(clk), .rst_n(rst_n), .cfg_master(d_master), .cfg_cpol(cpol), .cfg_cpha(cpha),
        .cfg_divisor(div), .wr_en(d_wr), .wr_data(d_wdata), .rd_en(d_rd), .rd_data(d_rdata),
        .done(d_done), .wcol(d_wcol), .busy(d_busy), .sck_o(d_sck_o), .sck_oe(d_sck_oe),
        .ss_n_o(d_ss_o), .mosi_o(d_mosi_o), .miso_i(p_miso_o),
        .sck_i(bb_en ? bb_sck : p_sck_o), .ss_n_i(bb_en ? bb_ss : p_ss_o),
        .mosi_i(bb_en ? bb_mosi : p_mosi_o), .miso_o(d_miso_o)
    );

    spi_byte_engine peer (
        .clk(clk), .rst_n(rst_n), .cfg_master(p_master), .cfg_cpol(cpol), .cfg_cpha(cpha),
        .cfg_divisor(div), .wr_en(p_wr), .wr_data(p_wdata), .rd_en(p_rd), .rd_data(p_rdata),
        .done(p_done), .wcol(p_wcol), .busy(p_busy), .sck_o(p_sck_o), .sck_oe(p_sck_oe),
        .ss_n_o(p_ss_o), .mosi_o(p_mosi_o), .miso_i(d_miso_o),
        .sck_i(d_sck_o), .ss_n_i(d_ss_o), .mosi_i(d_mosi_o), .miso_o(p_miso_o)
    );

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!ended) begin
            ended = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    task automatic wr(input bit to_dut, input logic [7:0] v);
        if (to_dut) begin d_wr = 1'b1; d_wdata = v; end
        else        begin p_wr = 1'b1; p_wdata = v; end
        cyc(1);
        d_wr = 1'b0; p_wr = 1'b0;
    endtask

    task automatic rd_both();
        d_rd = 1'b1; p_rd = 1'b1;
        cyc(1);
        d_rd = 1'b0; p_rd = 1'b0;
    endtask

    task automatic wait_idle(input bit dut_owner);
        for (int t = 0; t < 4000; t++) begin
            if (!(dut_owner ? d_busy : p_busy)) break;
            cyc(1);
        end
        cyc(8);
    endtask

    // Full loopback exchange; owner sends mt, follower sends st.
    task automatic xfer(input bit dut_owner, input logic [7:0] mt, input logic [7:0] st);
        wr(!dut_owner, st);
        wr(dut_owner, mt);
        cyc(2);
        wait_idle(dut_owner);
        check("R1 R2 owner rx", dut_owner ? d_rdata : p_rdata, st);
        check("R1 R2 follower rx", dut_owner ? p_rdata : d_rdata, mt);
        check("R7 owner done", dut_owner ? d_done : p_done, 1);
        check("R7 follower done", dut_owner ? p_done : d_done, 1);
        rd_both();
        check("R7 done cleared by read", {d_done, p_done}, 0);
    endtask

    // Bench-driven owner toward the dut in follower mode, half period 4 clocks.
    task automatic bang(input logic [7:0] tx, output logic [7:0] got);
        for (int i = 7; i >= 0; i--) begin
            if (!cpha) begin
                bb_mosi = tx[i]; cyc(4);
                got[i] = d_miso_o;
                bb_sck = ~cpol; cyc(4);
                bb_sck = cpol;
            end else begin
                bb_sck = ~cpol; bb_mosi = tx[i]; cyc(4);
                got[i] = d_miso_o;
                bb_sck = cpol; cyc(4);
            end
        end
        cyc(4);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        logic [7:0] got;
        logic       prev;
        int         c;
        cyc(4);
        rst_n = 1'b1;
        cyc(1);

        // R9: reset state
        check("R9 done", d_done, 0);
        check("R9 wcol", d_wcol, 0);
        check("R9 busy", d_busy, 0);
        check("R9 rd_data", d_rdata, 0);
        check("R9 ss_n_o", d_ss_o, 1);
        check("R9 sck_o idle", d_sck_o, cpol);
        check("R4 sck_oe owner", d_sck_oe, 1);
        check("R4 sck_oe follower", p_sck_oe, 0);

        // R1 R2: sweep roles, modes, divisors, patterns
        for (int role = 0; role < 2; role++) begin
            d_master = (role == 0);
            p_master = (role != 0);
            for (int m = 0; m < 4; m++) begin
                cpol = m[1];
                cpha = m[0];
                for (int dv = 0; dv < 2; dv++) begin
                    div = (dv == 0) ? 16'd4 : 16'd6;
                    cyc(6);
                    check("R2 idle level", (role == 0) ? d_sck_o : p_sck_o, cpol);
                    for (int k = 0; k < 6; k++) begin
                        logic [7:0] a, b;
                        a = 8'(k * 53 + 17 + m * 29);
                        b = ~a ^ 8'(k << 3);
                        xfer(role == 0, a, b);
                    end
                end
            end
        end
        d_master = 1'b1; p_master = 1'b0;

        // R3: half period equals clamped divisor; R4: select low during transfer
        cpol = 1'b0; cpha = 1'b0;
        for (int j = 0; j < 3; j++) begin
            div = (j == 0) ? 16'd0 : (j == 1) ? 16'd1 : 16'd3;
            cyc(4);
            wr(1, 8'h5C);
            prev = d_sck_o;
            for (int t = 0; t < 100 && d_sck_o == prev; t++) cyc(1);
            prev = d_sck_o;
            c = 0;
            for (int t = 0; t < 100 && d_sck_o == prev; t++) begin cyc(1); c++; end
            check("R3 half period", c, (div < 2) ? 2 : div);
            check("R4 select low in transfer", d_ss_o, 0);
            check("R4 busy in transfer", d_busy, 1);
            wait_idle(1);
            check("R4 select high after", d_ss_o, 1);
            rd_both();
        end

        // R10: first bit timing for the owner
        div = 16'd6; cpha = 1'b0;
        cyc(4);
        wr(0, 8'h00);
        wr(1, 8'h80);
        cyc(1);
        check("R10 cpha0 bit before edge", {d_sck_o, d_mosi_o}, {cpol, 1'b1});
        wait_idle(1); rd_both();
        cpha = 1'b1;
        cyc(4);
        wr(0, 8'h00);
        wr(1, 8'h80);
        prev = d_sck_o;
        for (int t = 0; t < 100 && d_sck_o == prev; t++) cyc(1);
        check("R10 cpha1 bit with first edge", d_mosi_o, 1);
        wait_idle(1); rd_both();

        // R8: write during transfer is ignored and flagged
        cpha = 1'b0;
        cyc(4);
        wr(0, 8'h55);
        wr(1, 8'hC6);
        cyc(20);
        wr(1, 8'h11);
        check("R8 wcol set", d_wcol, 1);
        wait_idle(1);
        check("R8 peer saw original byte", p_rdata, 8'hC6);
        check("R8 owner rx intact", d_rdata, 8'h55);
        rd_both();
        check("R8 wcol cleared by read", d_wcol, 0);

        // R7: completion and read in the same cycle; completion wins
        div = 16'd4;
        wr(0, 8'h2D);
        d_rd = 1'b1;
        wr(1, 8'hB4);
        for (int t = 0; t < 1000 && !d_done; t++) cyc(1);
        d_rd = 1'b0;
        cyc(2);
        check("R7 set beats clear", d_done, 1);
        check("R7 rx byte", d_rdata, 8'h2D);
        wait_idle(1); rd_both();

        // R5: follower, cpha 0, edges ignored while select high
        d_master = 1'b0; p_master = 1'b0; bb_en = 1'b1;
        cpol = 1'b1; cpha = 1'b0; bb_sck = 1'b1; bb_ss = 1'b1;
        cyc(8);
        wr(1, 8'hC3);
        bb_mosi = 1'b1;
        for (int i = 0; i < 8; i++) begin bb_sck = 1'b0; cyc(4); bb_sck = 1'b1; cyc(4); end
        check("R5 no completion with select high", d_done, 0);
        bb_ss = 1'b0; cyc(4);
        check("R5 first bit on select fall", d_miso_o, 1);
        bang(8'hA5, got);
        check("R5 follower tx", got, 8'hC3);
        check("R5 follower rx", d_rdata, 8'hA5);
        check("R5 done", d_done, 1);
        bb_ss = 1'b1; cyc(8); rd_both();

        // R6: follower, cpha 1, select held low across two bytes
        cpol = 1'b0; cpha = 1'b1; bb_sck = 1'b0;
        cyc(8);
        wr(1, 8'h81);
        bb_ss = 1'b0; cyc(4);
        bang(8'h5A, got);
        check("R6 byte1 tx", got, 8'h81);
        check("R6 byte1 rx", d_rdata, 8'h5A);
        check("R6 byte1 done", d_done, 1);
        rd_both();
        wr(1, 8'h7E);
        check("R6 write between bytes accepted", d_wcol, 0);
        bang(8'hC3, got);
        check("R6 byte2 tx", got, 8'h7E);
        check("R6 byte2 rx", d_rdata, 8'hC3);
        check("R6 byte2 done", d_done, 1);
        bb_ss = 1'b1; cyc(8);

        summary();
    end
endmodule